// File: doc/BRIEF.md
# Quad Read Engine with Execute-in-Place Continuation

This block is the read path of a serial flash device model. It watches chip select, the serial clock and four data lines, decodes the quad-output read and the quad I/O read commands, collects the address and dummy phases, and then streams bytes from a memory read port back onto the four data lines. Serial clock and chip select are sampled in the system clock domain. The serial clock must stay below a third of the system clock rate, and it idles low.

Position within a transaction is kept as one bit count. A single-line clock adds one and a quad clock adds four, so every phase boundary sits at a fixed count. At the end of a transaction a mode bit, captured during the dummy phase, decides whether the device stays in execute-in-place operation. In that mode the next transaction has no command byte and begins directly with a quad address.

Top module: `qrd_xip_reader`

## Requirements
- R1: After reset, dq_oe_o is 0, dq_o is 0, mem_addr_o is 0, and the first transaction is decoded as a normal command.
- R2: Command 0x6B is taken as 8 bits on dq_i[0], MSB first, sampled on SCK rising edges. It is followed by 24 address bits on dq_i[0], MSB first, and then 8 quad dummy clocks.
- R3: Command 0xEB is taken on dq_i[0]. The 24-bit address follows on dq_i[3:0] in 6 quad clocks, high nibble first (dq_i[3] is the most significant bit of each nibble), and then 8 quad dummy clocks.
- R4: The bit count advances by 1 per single-line clock and by 4 per quad clock. The command ends at count 8, the address at 32 and the dummy phase at 64. The data phase starts on the rising edge that brings the count to 64.
- R5: dq_i[0] on the first dummy clock is the continuation bit (bit 4 of the first dummy byte). When chip select rises after the data phase was reached, a 0 enters execute-in-place mode and a 1 returns to normal command decoding.
- R6: In execute-in-place mode a transaction has no command byte. It takes a 24-bit quad address in 6 clocks (count 24 from the start), then 8 dummy clocks (count 24+32), then data. This also holds after a 0x6B read whose address came in on one line.
- R7: In the data phase each byte is driven on dq_o[3:0], high nibble first. The nibble changes only after an SCK falling edge, and the first high nibble follows the falling edge after the count reaches 64. dq_oe_o is 1 only in the data phase while chip select is low.
- R8: Successive bytes come from successive addresses on mem_addr_o, starting at the captured address.
- R9: The address is masked to MEM_AW bits, so address bits above MEM_AW are dropped and the byte after address 2^MEM_AW-1 is read from address 0.
- R10: A byte whose high nibble is driven while wip_i is 1 is sent as 0x00 instead of memory data.
- R11: Any command other than 0x6B or 0xEB is ignored until chip select rises, with dq_oe_o held at 0.
- R12: If chip select rises before the data phase, execute-in-place mode is left and the next transaction expects a command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples all serial signals |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock, idle low |
| dq_i | input | 4 | Data lines from host; dq_i[0] carries single-line bits |
| wip_i | input | 1 | Write-in-progress flag; forces zero data |
| mem_data_i | input | 8 | Byte read at mem_addr_o, same cycle |
| mem_addr_o | output | MEM_AW | Memory read address |
| dq_o | output | 4 | Data nibble to host |
| dq_oe_o | output | 1 | Drive enable for dq_o |

## Verification
The hardest situation to reach is the execute-in-place chain. A transaction starts with no command byte only when the previous one reached its data phase with the continuation bit clear. The stimulus therefore builds chains of transactions: a quad I/O read with the continuation bit clear, a command-less follow-up that sets the bit, and then a normal command that reads correct data only if the mode was really left. Further chains start from a single-line-address read, and one abandons a command-less transaction halfway through its address.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } qrd_state_e;

  localparam int          CNT_W      = 7;
  localparam logic [7:0]  CMD_QOUT   = 8'h6B;
  localparam logic [7:0]  CMD_QIO    = 8'hEB;
  localparam int          CNT_CMD    = 8;
  localparam int          CNT_ADDR   = 32;
  localparam int          CNT_DATA   = 64;
endpackage

// File: rtl/qrd_edge.sv
module qrd_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= RST_VAL;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/qrd_shift.sv
module qrd_shift #(
  parameter int SH_W  = 20,
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [CNT_W-1:0] init_cnt_i,
  input  logic             step_i,
  input  logic             quad_i,
  input  logic [3:0]       dq_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nx_o,
  output logic [SH_W-1:0]  sh_nx_o
);
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;

  // upper address bits fall off the top: this is the size mask
  always_comb begin
    if (quad_i) begin
      sh_nx_o  = {sh_q[SH_W-5:0], dq_i};
      cnt_nx_o = cnt_q + CNT_W'(4);
    end else begin
      sh_nx_o  = {sh_q[SH_W-2:0], dq_i[0]};
      cnt_nx_o = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (init_i) begin
      sh_q  <= '0;
      cnt_q <= init_cnt_i;
    end else if (step_i) begin
      sh_q  <= sh_nx_o;
      cnt_q <= cnt_nx_o;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/qrd_stream.sv
module qrd_stream #(
  parameter int MEM_AW = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic              fall_i,
  input  logic              active_i,
  input  logic              wip_i,
  input  logic [7:0]        mem_data_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [3:0]        dq_o
);
  logic [MEM_AW-1:0] addr_q;
  logic              lo_next_q;
  logic [3:0]        lo_q;
  logic [3:0]        dq_q;
  logic [7:0]        byte_src;

  assign byte_src = wip_i ? 8'h00 : mem_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      lo_next_q <= 1'b0;
      lo_q      <= '0;
      dq_q      <= '0;
    end else if (load_i) begin
      addr_q    <= addr_i;
      lo_next_q <= 1'b0;
    end else if (active_i && fall_i) begin
      if (!lo_next_q) begin
        dq_q      <= byte_src[7:4];
        lo_q      <= byte_src[3:0];
        lo_next_q <= 1'b1;
      end else begin
        dq_q      <= lo_q;
        lo_next_q <= 1'b0;
        addr_q    <= addr_q + MEM_AW'(1);
      end
    end
  end

  assign mem_addr_o = addr_q;
  assign dq_o       = dq_q;
endmodule

// File: rtl/qrd_xip_reader.sv
module qrd_xip_reader
  import qrd_pkg::*;
#(
  parameter int MEM_AW = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic [3:0]        dq_i,
  input  logic              wip_i,
  input  logic [7:0]        mem_data_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [3:0]        dq_o,
  output logic              dq_oe_o
);
  localparam int SH_W = MEM_AW;

  qrd_state_e        st_q;
  logic              quad_q, xip_q, mode_q;
  logic [MEM_AW-1:0] addr_q;
  logic              sck_rise_raw, sck_fall_raw, sck_rise, sck_fall;
  logic              cs_rise, cs_fall;
  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic [SH_W-1:0]   sh_nx;
  logic              shift_step, data_load;

  qrd_edge #(.RST_VAL(1'b0)) u_sck_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sck_i),
    .rise_o(sck_rise_raw), .fall_o(sck_fall_raw)
  );

  qrd_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(cs_ni),
    .rise_o(cs_rise), .fall_o(cs_fall)
  );

  assign sck_rise = sck_rise_raw & ~cs_ni;
  assign sck_fall = sck_fall_raw & ~cs_ni;

  assign shift_step = sck_rise &&
                      (st_q == ST_CMD || st_q == ST_ADDR || st_q == ST_DUMMY);

  // continuation transactions start past the missing command byte
  qrd_shift #(.SH_W(SH_W), .CNT_W(CNT_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .init_i(cs_fall),
    .init_cnt_i(xip_q ? CNT_W'(CNT_CMD) : CNT_W'(0)),
    .step_i(shift_step), .quad_i(quad_q), .dq_i(dq_i),
    .cnt_o(cnt), .cnt_nx_o(cnt_nx), .sh_nx_o(sh_nx)
  );

  assign data_load = sck_rise && (st_q == ST_DUMMY) &&
                     (cnt_nx == CNT_W'(CNT_DATA));

  qrd_stream #(.MEM_AW(MEM_AW)) u_stream (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(data_load), .addr_i(addr_q),
    .fall_i(sck_fall), .active_i(st_q == ST_DATA),
    .wip_i(wip_i), .mem_data_i(mem_data_i),
    .mem_addr_o(mem_addr_o), .dq_o(dq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      quad_q <= 1'b0;
      xip_q  <= 1'b0;
      mode_q <= 1'b1;
      addr_q <= '0;
    end else if (cs_rise) begin
      xip_q  <= (st_q == ST_DATA) && !mode_q;
      st_q   <= ST_IDLE;
      quad_q <= 1'b0;
    end else if (cs_fall) begin
      st_q   <= xip_q ? ST_ADDR : ST_CMD;
      quad_q <= xip_q;
      mode_q <= 1'b1;
    end else if (sck_rise) begin
      unique case (st_q)
        ST_CMD: begin
          if (cnt_nx == CNT_W'(CNT_CMD)) begin
            if (sh_nx[7:0] == CMD_QOUT) begin
              st_q <= ST_ADDR;
            end else if (sh_nx[7:0] == CMD_QIO) begin
              st_q   <= ST_ADDR;
              quad_q <= 1'b1;
            end else begin
              st_q <= ST_SKIP;
            end
          end
        end
        ST_ADDR: begin
          if (cnt_nx == CNT_W'(CNT_ADDR)) begin
            addr_q <= sh_nx;
            st_q   <= ST_DUMMY;
            quad_q <= 1'b1;
          end
        end
        ST_DUMMY: begin
          if (cnt == CNT_W'(CNT_ADDR)) mode_q <= dq_i[0];
          if (cnt_nx == CNT_W'(CNT_DATA)) st_q <= ST_DATA;
        end
        default: ;
      endcase
    end
  end

  assign dq_oe_o = (st_q == ST_DATA) && !cs_ni;
endmodule

// File: rtl/qrd_xip_reader_chk.sv
module qrd_xip_reader_chk #(
  parameter int MEM_AW = 20,
  parameter int CNT_W  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              sck_i,
  input logic [3:0]        dq_o,
  input logic              dq_oe_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic              xip_i,
  input logic [CNT_W-1:0]  cnt_i
);
  // R7: a nibble changes only after a sampled falling SCK edge
  a_r7_dq_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dq_o) |-> (!$past(sck_i) && $past(sck_i, 2)));

  a_r7_oe_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> $past(sck_i));

  a_r4_data_at_64: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (cnt_i == CNT_W'(64)));

  a_r8_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mem_addr_o) && $past(dq_oe_o) && dq_oe_o)
      |-> (mem_addr_o == MEM_AW'($past(mem_addr_o) + MEM_AW'(1))));

  a_r5_xip_at_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xip_i) |-> $past(cs_ni));
endmodule

bind qrd_xip_reader qrd_xip_reader_chk #(.MEM_AW(MEM_AW), .CNT_W(qrd_pkg::CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i),
  .dq_o(dq_o), .dq_oe_o(dq_oe_o), .mem_addr_o(mem_addr_o),
  .xip_i(xip_q), .cnt_i(cnt)
);

// File: tb/tb_qrd_xip_reader.sv
module tb_qrd_xip_reader;
  localparam int MEM_AW = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cs_n = 1'b1;
  logic              sck = 1'b0;
  logic              wip = 1'b0;
  logic [3:0]        dq_drv = 4'h0;
  logic [7:0]        mem_data;
  logic [MEM_AW-1:0] mem_addr;
  logic [3:0]        dq_out;
  logic              dq_oe;
  int                checks = 0;
  int                fails = 0;
  bit                done = 1'b0;

  always #10 clk = ~clk;

  qrd_xip_reader #(.MEM_AW(MEM_AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .dq_i(dq_drv),
    .wip_i(wip), .mem_data_i(mem_data), .mem_addr_o(mem_addr),
    .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  function automatic logic [7:0] memf(input logic [MEM_AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h3C;
  endfunction

  always_comb mem_data = memf(mem_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qclk(input logic [3:0] nib, output logic [3:0] got);
    @(negedge clk);
    dq_drv = nib;
    sck    = 1'b1;
    repeat (3) @(negedge clk);
    sck = 1'b0;
    repeat (3) @(negedge clk);
    got = dq_out;
  endtask

  task automatic sel();
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_single(input logic [31:0] v, input int n);
    logic [3:0] g;
    for (int i = n - 1; i >= 0; i--) qclk({3'b000, v[i]}, g);
  endtask

  task automatic send_quad(input logic [23:0] v, input int n);
    logic [3:0] g;
    for (int i = 5; i > 5 - n; i--) qclk(v[i*4 +: 4], g);
  endtask

  task automatic dummy_ph(input logic [7:0] mode, output logic [3:0] hi);
    logic [3:0] g;
    qclk(mode[7:4], g);
    qclk(mode[3:0], g);
    for (int i = 0; i < 5; i++) qclk(4'h0, g);
    qclk(4'h0, hi);
  endtask

  task automatic read_chk(input logic [3:0] hi0, input logic [MEM_AW-1:0] a0,
                          input int n, input bit zero, input string req);
    logic [3:0] hi, lo;
    logic [7:0] exp;
    logic [MEM_AW-1:0] a;
    hi = hi0;
    chk(dq_oe == 1'b1, {req, " R7 oe"}, dq_oe, 1);
    for (int b = 0; b < n; b++) begin
      qclk(4'h0, lo);
      a   = a0 + MEM_AW'(b);
      exp = zero ? 8'h00 : memf(a);
      chk({hi, lo} == exp, req, {hi, lo}, exp);
      if (b < n - 1) qclk(4'h0, hi);
    end
  endtask

  task automatic qout_read(input logic [23:0] addr, input logic [7:0] mode,
                           input int n, input bit zero, input string req);
    logic [3:0] hi;
    sel();
    send_single(32'h6B, 8);
    send_single({8'h00, addr}, 24);
    dummy_ph(mode, hi);
    read_chk(hi, MEM_AW'(addr), n, zero, req);
    desel();
  endtask

  task automatic qio_read(input logic [23:0] addr, input logic [7:0] mode,
                          input int n, input string req);
    logic [3:0] hi;
    sel();
    send_single(32'hEB, 8);
    send_quad(addr, 6);
    dummy_ph(mode, hi);
    read_chk(hi, MEM_AW'(addr), n, 1'b0, req);
    desel();
  endtask

  task automatic xip_read(input logic [23:0] addr, input logic [7:0] mode,
                          input int n, input string req);
    logic [3:0] hi;
    sel();
    send_quad(addr, 6);
    dummy_ph(mode, hi);
    read_chk(hi, MEM_AW'(addr), n, 1'b0, req);
    desel();
  endtask

  task automatic t_reset();
    chk(dq_oe == 1'b0, "R1 oe", dq_oe, 0);
    chk(dq_out == 4'h0, "R1 dq", dq_out, 0);
    chk(mem_addr == '0, "R1 addr", mem_addr, 0);
  endtask

  task automatic t_qout_basic();
    qout_read(24'h012345, 8'hFF, 4, 1'b0, "R2 R4 R8 qout");
    qout_read(24'h00A5A0, 8'hFF, 2, 1'b0, "R1 R5 normal after mode 1");
  endtask

  task automatic t_qio_xip();
    qio_read(24'h0ABCDE, 8'h00, 3, "R3 R4 qio");
    xip_read(24'h00F00F, 8'h10, 2, "R6 xip after qio");
    qout_read(24'h000333, 8'hFF, 2, 1'b0, "R5 exit xip");
  endtask

  task automatic t_qout_to_xip();
    qout_read(24'h002468, 8'hEF, 1, 1'b0, "R5 bit4 only");
    xip_read(24'h054321, 8'hFF, 2, "R6 xip after qout");
    qout_read(24'h000111, 8'hFF, 1, 1'b0, "R5 back to normal");
  endtask

  task automatic t_wrap_mask();
    qout_read(24'h3FFFFE, 8'hFF, 3, 1'b0, "R9 R8 mask wrap");
  endtask

  task automatic t_wip();
    wip = 1'b1;
    qout_read(24'h000100, 8'hFF, 2, 1'b1, "R10 wip zeros");
    wip = 1'b0;
  endtask

  task automatic t_bad_cmd();
    logic [3:0] g;
    bit oe_seen;
    oe_seen = 1'b0;
    sel();
    send_single(32'h03, 8);
    for (int i = 0; i < 40; i++) begin
      qclk(4'hF, g);
      if (dq_oe) oe_seen = 1'b1;
    end
    chk(!oe_seen, "R11 ignored cmd", oe_seen, 0);
    desel();
    qout_read(24'h000042, 8'hFF, 1, 1'b0, "R11 recover");
  endtask

  task automatic t_abort();
    qio_read(24'h001234, 8'h00, 1, "R12 enter xip");
    sel();
    send_quad(24'h0FFFFF, 3);
    desel();
    qout_read(24'h000777, 8'hFF, 2, 1'b0, "R12 abort leaves xip");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_qout_basic();
    t_qio_xip();
    t_qout_to_xip();
    t_wrap_mask();
    t_wip();
    t_bad_cmd();
    t_abort();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule